// File: doc/BRIEF.md
# Latched Motion-Sensor Interrupt Status

This block gathers interrupt events from the motion-sensing functions of an accelerometer front end into one packed status byte. The sources are free-fall, buffer-full, watermark, new-data-ready, tap result, wake-up and tilt-change. Each bit latches when its event arrives. Each bit also has its own clearing rule, tied to what the host reads: the release register, the acceleration output registers, or the sample buffer. A combined interrupt output is high whenever any status bit is set.

A bus front end decodes host reads into single-cycle strobes. The detection engines deliver single-cycle event pulses. The status byte that is visible in the cycle of a release read is the value the host receives, so the read returns the status from before the clear. If an event and a clearing read arrive in the same cycle, the event takes priority.

Top module: `intr_status_latch`

## Requirements
- R1: After a synchronous reset, `status` is 8'h00 and `irq_any` is 0.
- R2: The status byte packs its fields as follows: bit 7 free-fall, bit 6 buffer full, bit 5 watermark, bit 4 data ready, bits 3:2 tap result, bit 1 wake-up, bit 0 tilt. An event pulse shows in its bit from the clock edge after the pulse.
- R3: The tap field reads 2'b01 after a single tap and 2'b10 after a double tap. It never reads 2'b11. If both pulses arrive together, it takes 2'b10. A later tap event replaces the earlier value.
- R4: The data-ready bit sets only when `drdy_en` is 1 during the `ev_drdy` pulse. It clears on `rd_data` or on `rd_release`.
- R5: The wake-up, tilt and free-fall bits clear only on `rd_release`. The strobes `rd_data`, `rd_buf` and `rd_status` leave them unchanged.
- R6: The buffer-full bit clears only on `rd_buf`.
- R7: The watermark bit sets in any cycle where `buf_fill >= wm_thresh`. It clears only in a cycle where `rd_buf` is high and `buf_fill < wm_thresh`. A fill that drops below the threshold without a buffer read leaves the bit set.
- R8: `irq_any` is 1 exactly when at least one status bit is set.
- R9: When an event pulse and a strobe that would clear the same bit arrive in the same cycle, the bit is set after that edge.
- R10: One `rd_release` clears free-fall, wake-up, tilt, data ready and the tap field together in one cycle. During that read cycle, `status` still shows the value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_freefall | input | 1 | Free-fall event pulse |
| ev_buf_full | input | 1 | Sample buffer full pulse |
| ev_drdy | input | 1 | New acceleration data pulse |
| drdy_en | input | 1 | Control enable for data-ready reporting |
| ev_tap_single | input | 1 | Single tap detected pulse |
| ev_tap_double | input | 1 | Double tap detected pulse |
| ev_wake | input | 1 | Wake-up (motion) event pulse |
| ev_tilt | input | 1 | Tilt position change pulse |
| buf_fill | input | LVL_W | Current sample buffer fill level |
| wm_thresh | input | LVL_W | Watermark threshold |
| rd_status | input | 1 | Read strobe of the status register (no clear) |
| rd_data | input | 1 | Read strobe of the acceleration output registers |
| rd_release | input | 1 | Read strobe of the release register |
| rd_buf | input | 1 | Read strobe of the sample buffer |
| status | output | 8 | Packed latched status byte |
| irq_any | output | 1 | OR of all active status bits |

## Verification
The hardest case to reach is a collision: a clearing read and a new event for the same bit land on one clock edge. The directed tasks create it on purpose by driving `rd_release` together with `ev_wake`, and `rd_data` together with `ev_drdy`. The watermark clear rule needs a specific order: first raise the fill above the threshold, then lower it with no read, and only then issue a buffer read. This order separates the level condition from the read condition.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    typedef enum logic [1:0] {
        TAP_NONE = 2'b00,
        TAP_ONE  = 2'b01,
        TAP_TWO  = 2'b10
    } tap_e;

    typedef struct packed {
        logic ff;
        logic bfull;
        logic wmark;
        logic drdy;
        tap_e tap;
        logic wake;
        logic tilt;
    } stat_t;

    // indices of the simple sticky flags
    localparam int unsigned N_STICKY = 5;
    localparam int unsigned SX_FF    = 0;
    localparam int unsigned SX_BF    = 1;
    localparam int unsigned SX_DR    = 2;
    localparam int unsigned SX_WK    = 3;
    localparam int unsigned SX_TL    = 4;

    function automatic tap_e tap_next(tap_e cur, logic one, logic two, logic clr);
        if (two)      return TAP_TWO;
        else if (one) return TAP_ONE;
        else if (clr) return TAP_NONE;
        return cur;
    endfunction

endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/tap_field.sv
module tap_field
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic one_i,
    input  logic two_i,
    input  logic clr_i,
    output tap_e tap_o
);
    always_ff @(posedge clk) begin
        if (rst) tap_o <= TAP_NONE;
        else     tap_o <= tap_next(tap_o, one_i, two_i, clr_i);
    end
endmodule

// File: rtl/wm_tracker.sv
module wm_tracker #(
    parameter int unsigned LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] fill_i,
    input  logic [LVL_W-1:0] thresh_i,
    input  logic             rd_buf_i,
    output logic             q_o
);
    logic at_or_above;
    assign at_or_above = (fill_i >= thresh_i);

    always_ff @(posedge clk) begin
        if (rst)                      q_o <= 1'b0;
        else if (at_or_above)         q_o <= 1'b1;
        else if (rd_buf_i)            q_o <= 1'b0;
    end
endmodule

// File: rtl/intr_status_latch.sv
module intr_status_latch
    import irq_stat_pkg::*;
#(
    parameter int unsigned LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_freefall,
    input  logic             ev_buf_full,
    input  logic             ev_drdy,
    input  logic             drdy_en,
    input  logic             ev_tap_single,
    input  logic             ev_tap_double,
    input  logic             ev_wake,
    input  logic             ev_tilt,
    input  logic [LVL_W-1:0] buf_fill,
    input  logic [LVL_W-1:0] wm_thresh,
    input  logic             rd_status,
    input  logic             rd_data,
    input  logic             rd_release,
    input  logic             rd_buf,
    output logic [7:0]       status,
    output logic             irq_any
);
    logic [N_STICKY-1:0] set_v, clr_v, q_v;
    logic                wm_q;
    tap_e                tap_q;
    stat_t               st;
    logic                unused_rd;

    assign unused_rd = rd_status; // reading status has no side effect

    always_comb begin
        set_v        = '0;
        clr_v        = '0;
        set_v[SX_FF] = ev_freefall;
        clr_v[SX_FF] = rd_release;
        set_v[SX_BF] = ev_buf_full;
        clr_v[SX_BF] = rd_buf;
        set_v[SX_DR] = ev_drdy & drdy_en;
        clr_v[SX_DR] = rd_data | rd_release;
        set_v[SX_WK] = ev_wake;
        clr_v[SX_WK] = rd_release;
        set_v[SX_TL] = ev_tilt;
        clr_v[SX_TL] = rd_release;
    end

    for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
        sticky_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (q_v[i])
        );
    end

    tap_field u_tap (
        .clk   (clk),
        .rst   (rst),
        .one_i (ev_tap_single),
        .two_i (ev_tap_double),
        .clr_i (rd_release),
        .tap_o (tap_q)
    );

    wm_tracker #(.LVL_W(LVL_W)) u_wm (
        .clk      (clk),
        .rst      (rst),
        .fill_i   (buf_fill),
        .thresh_i (wm_thresh),
        .rd_buf_i (rd_buf),
        .q_o      (wm_q)
    );

    always_comb begin
        st.ff    = q_v[SX_FF];
        st.bfull = q_v[SX_BF];
        st.wmark = wm_q;
        st.drdy  = q_v[SX_DR];
        st.tap   = tap_q;
        st.wake  = q_v[SX_WK];
        st.tilt  = q_v[SX_TL];
    end

    assign status  = st;
    assign irq_any = |st;

endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
    parameter int unsigned LVL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_freefall,
    input logic             ev_buf_full,
    input logic             ev_drdy,
    input logic             drdy_en,
    input logic             ev_tap_single,
    input logic             ev_tap_double,
    input logic             ev_wake,
    input logic             ev_tilt,
    input logic [LVL_W-1:0] buf_fill,
    input logic [LVL_W-1:0] wm_thresh,
    input logic             rd_status,
    input logic             rd_data,
    input logic             rd_release,
    input logic             rd_buf,
    input logic [7:0]       status,
    input logic             irq_any
);
    // R3
    tap_never11_chk: assert property (@(posedge clk) disable iff (rst)
        status[3:2] != 2'b11);

    // R5
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        status[1] && !rd_release |=> status[1]);

    // R10
    release_clr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_release && !ev_wake && !ev_tilt |=> status[1:0] == 2'b00);

    // R9
    ff_event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ev_freefall |=> status[7]);

    // R6
    bfull_hold_chk: assert property (@(posedge clk) disable iff (rst)
        status[6] && !rd_buf |=> status[6]);

    // R4
    drdy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !status[4] && !(ev_drdy && drdy_en) |=> !status[4]);

    // R7
    wm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        status[5] && !rd_buf |=> status[5]);
endmodule

bind intr_status_latch irq_stat_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/intr_status_latch_tb.sv
module intr_status_latch_tb;
    localparam int unsigned LVL_W = 10;

    logic clk = 1'b0;
    logic rst;
    logic ev_freefall, ev_buf_full, ev_drdy, drdy_en;
    logic ev_tap_single, ev_tap_double, ev_wake, ev_tilt;
    logic [LVL_W-1:0] buf_fill, wm_thresh;
    logic rd_status, rd_data, rd_release, rd_buf;
    logic [7:0] status;
    logic irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    intr_status_latch #(.LVL_W(LVL_W)) u_dut (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ev_freefall = 0; ev_buf_full = 0; ev_drdy = 0;
        ev_tap_single = 0; ev_tap_double = 0; ev_wake = 0; ev_tilt = 0;
        rd_status = 0; rd_data = 0; rd_release = 0; rd_buf = 0;
    endtask

    // one clock edge, inputs dropped afterwards, sample at negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        drdy_en = 1; buf_fill = 0; wm_thresh = 10'd8;
        rst = 1;
        tick(); tick();
        rst = 0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        buf_fill = 0;
        rd_release = 1; rd_buf = 1; tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 irq", {7'd0, irq_any}, 8'h00);
    endtask

    task automatic t_layout();
        ev_freefall = 1; tick(); chk("R2 freefall", status, 8'h80); clear_all();
        ev_buf_full = 1; tick(); chk("R2 bfull", status, 8'h40); clear_all();
        ev_drdy = 1; tick(); chk("R2 drdy", status, 8'h10); clear_all();
        ev_wake = 1; tick(); chk("R2 wake", status, 8'h02); clear_all();
        ev_tilt = 1; tick(); chk("R2 tilt", status, 8'h01); clear_all();
        chk("R8 idle irq", {7'd0, irq_any}, 8'h00);
    endtask

    task automatic t_tap();
        ev_tap_single = 1; tick(); chk("R3 single", status, 8'h04);
        ev_tap_double = 1; tick(); chk("R3 double replaces", status, 8'h08);
        ev_tap_single = 1; tick(); chk("R3 single replaces", status, 8'h04);
        ev_tap_single = 1; ev_tap_double = 1; tick();
        chk("R3 both", status, 8'h08);
        chk("R8 irq tap", {7'd0, irq_any}, 8'h01);
        rd_release = 1; tick(); chk("R10 tap cleared", status, 8'h00);
    endtask

    task automatic t_drdy();
        drdy_en = 0; ev_drdy = 1; tick();
        chk("R4 gated", status, 8'h00);
        drdy_en = 1; ev_drdy = 1; tick();
        chk("R4 set", status, 8'h10);
        rd_data = 1; tick(); chk("R4 data read clears", status, 8'h00);
        ev_drdy = 1; tick();
        rd_release = 1; tick(); chk("R4 release clears", status, 8'h00);
    endtask

    task automatic t_release_only();
        ev_wake = 1; ev_tilt = 1; ev_freefall = 1; tick();
        rd_data = 1; tick(); chk("R5 data read no effect", status, 8'h83);
        rd_buf = 1; tick(); chk("R5 buf read no effect", status, 8'h83);
        rd_status = 1; tick(); chk("R5 status read no effect", status, 8'h83);
        chk("R8 irq", {7'd0, irq_any}, 8'h01);
        ev_drdy = 1; ev_tap_double = 1; tick();
        rd_release = 1;
        #1 chk("R10 value during read", status, 8'h9B);
        tick(); chk("R10 all cleared", status, 8'h00);
        chk("R8 irq low", {7'd0, irq_any}, 8'h00);
    endtask

    task automatic t_buffer();
        ev_buf_full = 1; tick();
        rd_release = 1; tick(); chk("R6 release no effect", status, 8'h40);
        rd_data = 1; tick(); chk("R6 data read no effect", status, 8'h40);
        rd_buf = 1; tick(); chk("R6 buf read clears", status, 8'h00);
    endtask

    task automatic t_watermark();
        wm_thresh = 10'd4; buf_fill = 10'd3; tick();
        chk("R7 below no set", status, 8'h00);
        buf_fill = 10'd4; tick(); chk("R7 at threshold", status, 8'h20);
        buf_fill = 10'd2; tick(); chk("R7 fall without read", status, 8'h20);
        rd_release = 1; tick(); chk("R7 release no effect", status, 8'h20);
        buf_fill = 10'd5; tick();
        rd_buf = 1; buf_fill = 10'd4; tick();
        chk("R7 read still at level", status, 8'h20);
        rd_buf = 1; buf_fill = 10'd3; tick();
        chk("R7 read below clears", status, 8'h00);
        buf_fill = 0;
    endtask

    task automatic t_collision();
        ev_wake = 1; tick();
        ev_wake = 1; rd_release = 1; tick();
        chk("R9 wake vs release", status, 8'h02);
        ev_drdy = 1; rd_data = 1; tick();
        chk("R9 drdy vs data read", status, 8'h12);
        ev_buf_full = 1; rd_buf = 1; tick();
        chk("R9 bfull vs buf read", status, 8'h52);
        clear_all();
        chk("R9 cleared after", status, 8'h00);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_tap();
        t_drdy();
        t_release_only();
        t_buffer();
        t_watermark();
        t_collision();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule